// File: doc/BRIEF.md
# Dual Time-Match Alarm Interrupt Controller

This block watches a running time-of-day value and, once per second, compares it with two independently programmed alarm values. Each alarm owns a sticky status flag that is set on every match, even when that alarm is not allowed to drive the interrupt. The flags stay set until a status read reaches its eighth bit clock. The serial front end marks that point with a one-cycle strobe, and the strobe clears both flags together.

A shared active-low interrupt line reports the matches of the enabled alarms. The mode input selects how it behaves. In single-event mode the line follows the flags: it drops when an enabled alarm's flag is set and stays low until the flags are read. In pulsed mode each qualifying match drives the line low for a fixed, parameterised number of cycles. Whenever the frequency output is enabled, the pin is in use for that purpose, so the interrupt function is suppressed and the line is held high. The line is registered, so it lags the flags by one cycle.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset both alarm flags are 0 and `irq_n` is 1.
- R2: When `sec_tick` is 1 and `cur_time` equals an alarm value, that alarm's flag (bit 0 for alarm 0, bit 1 for alarm 1) is 1 from the next cycle onwards. This happens whatever the enable, mode and frequency-output inputs are.
- R3: A match without `sec_tick` never sets a flag.
- R4: A one-cycle `stat_rd_clr` clears both flags in the next cycle.
- R5: When a set and a clear reach the same flag in the same cycle, the set wins.
- R6: In single-event mode (`irq_mode` = 0) with `fout_en` = 0, `irq_n` is low one cycle after any flag whose enable bit is 1 is set. It stays low until the flags are cleared, and goes high one cycle after the clear.
- R7: A flag whose enable bit (`alm_en[0]` for alarm 0, `alm_en[1]` for alarm 1) is 0 never pulls `irq_n` low.
- R8: In pulsed mode (`irq_mode` = 1) with `fout_en` = 0, a ticked match of an enabled alarm drives `irq_n` low for exactly PULSE_LEN consecutive cycles, starting two cycles after the tick.
- R9: In pulsed mode the flags are still set by matches, stay set after the pulse ends, and clear only on `stat_rd_clr`.
- R10: While `fout_en` is 1, `irq_n` is 1 from the next cycle. If enabled flags are still set when `fout_en` returns to 0 in single-event mode, the line goes low again.
- R11: Either alarm alone can assert the shared line, and both alarms may match on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe at each second boundary |
| cur_time | input | FIELD_W*N_FIELDS | Current time-of-day fields |
| alm0_val | input | FIELD_W*N_FIELDS | Alarm 0 compare value |
| alm1_val | input | FIELD_W*N_FIELDS | Alarm 1 compare value |
| alm_en | input | 2 | Per-alarm interrupt enable |
| irq_mode | input | 1 | 0 = single-event, 1 = pulsed |
| fout_en | input | 1 | Frequency output owns the pin; interrupt suppressed |
| stat_rd_clr | input | 1 | Eighth bit clock of a status read; clears flags |
| alm_flag | output | 2 | Sticky alarm status flags |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
A flag register that drops an event shows up at `alm_flag` one cycle after the tick. Because that flag also feeds the single-event line, the same fault appears at `irq_n` one cycle later. A pulse counter that loads or counts down wrongly changes the number of low cycles on `irq_n`, which the bench counts exactly. A lost priority between set and clear shows when a tick and a status read land on the same cycle. A missing frequency-output mask leaves `irq_n` low in the cycle after `fout_en` rises.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
   localparam int unsigned NUM_ALARMS = 2;

   typedef enum logic {
      IRQ_SINGLE = 1'b0,
      IRQ_PULSED = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
   parameter int unsigned FIELD_W  = 8,
   parameter int unsigned N_FIELDS = 3,
   localparam int unsigned TIME_W  = FIELD_W * N_FIELDS
) (
   input  logic              tick,
   input  logic [TIME_W-1:0] now_val,
   input  logic [TIME_W-1:0] ref_val,
   output logic              hit
);
   logic [N_FIELDS-1:0] fld_eq;

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      assign fld_eq[f] = (now_val[f*FIELD_W +: FIELD_W] == ref_val[f*FIELD_W +: FIELD_W]);
   end

   assign hit = tick & (&fld_eq);
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_o[i] <= 1'b0;
         else if (set_i[i])  flag_o[i] <= 1'b1;
         else if (clr_i)     flag_o[i] <= 1'b0;
      end

      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_o[i]);
      a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !set_i[i]) |=> !flag_o[i]);
      a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !flag_o[i]) |=> !flag_o[i]);
   end
endmodule

// File: rtl/irq_pulse.sv
module irq_pulse #(
   parameter int unsigned PULSE_LEN = 16,
   localparam int unsigned CNT_W    = $clog2(PULSE_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic active_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (fire_i)        cnt_q <= CNT_W'(PULSE_LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   a_r8_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> active_o);
   a_r8_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !fire_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
   import alarm_irq_pkg::*;
#(
   parameter int unsigned FIELD_W   = 8,
   parameter int unsigned N_FIELDS  = 3,
   parameter int unsigned PULSE_LEN = 16,
   localparam int unsigned TIME_W   = FIELD_W * N_FIELDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] alm0_val,
   input  logic [TIME_W-1:0] alm1_val,
   input  logic [1:0]        alm_en,
   input  logic              irq_mode,
   input  logic              fout_en,
   input  logic              stat_rd_clr,
   output logic [1:0]        alm_flag,
   output logic              irq_n
);
   if (FIELD_W < 1 || N_FIELDS < 1) begin : g_bad_time
      $error("alarm_irq_ctrl: time fields must be non-empty");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("alarm_irq_ctrl: PULSE_LEN must be at least 1");
   end

   logic [TIME_W-1:0]     ref_val [NUM_ALARMS];
   logic [NUM_ALARMS-1:0] hit;
   logic                  pulse_fire;
   logic                  pulse_act;
   irq_mode_e             mode;
   logic                  irq_n_d;

   assign ref_val[0] = alm0_val;
   assign ref_val[1] = alm1_val;
   assign mode       = irq_mode_e'(irq_mode);

   for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
      alarm_cmp #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_cmp (
         .tick    (sec_tick),
         .now_val (cur_time),
         .ref_val (ref_val[a]),
         .hit     (hit[a])
      );
   end

   alarm_flags #(.N(NUM_ALARMS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit),
      .clr_i  (stat_rd_clr),
      .flag_o (alm_flag)
   );

   assign pulse_fire = (mode == IRQ_PULSED) && !fout_en && |(hit & alm_en);

   irq_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (pulse_fire),
      .active_o (pulse_act)
   );

   always_comb begin
      if (fout_en)                 irq_n_d = 1'b1;
      else if (mode == IRQ_PULSED) irq_n_d = !pulse_act;
      else                         irq_n_d = !(|(alm_flag & alm_en));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= irq_n_d;
   end

   a_r10_fout_releases: assert property (@(posedge clk) disable iff (!rst_n)
      fout_en |=> irq_n);
   a_r6_single_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!fout_en && !irq_mode && |(alm_flag & alm_en)) |=> !irq_n);
   a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_mode && !(|(alm_flag & alm_en))) |=> irq_n);
   a_r2_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && cur_time == alm1_val) |=> alm_flag[1]);
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
   localparam int unsigned FW = 8;
   localparam int unsigned NF = 3;
   localparam int unsigned TW = FW * NF;
   localparam int unsigned PL = 4;
   localparam logic [TW-1:0] T0 = 24'h123456;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [TW-1:0] cur_time = '0;
   logic [TW-1:0] alm0_val = '1;
   logic [TW-1:0] alm1_val = '1;
   logic [1:0]    alm_en = '0;
   logic          irq_mode = 1'b0;
   logic          fout_en = 1'b0;
   logic          stat_rd_clr = 1'b0;
   logic [1:0]    alm_flag;
   logic          irq_n;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   alarm_irq_ctrl #(.FIELD_W(FW), .N_FIELDS(NF), .PULSE_LEN(PL)) dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_time(cur_time),
      .alm0_val(alm0_val), .alm1_val(alm1_val), .alm_en(alm_en),
      .irq_mode(irq_mode), .fout_en(fout_en), .stat_rd_clr(stat_rd_clr),
      .alm_flag(alm_flag), .irq_n(irq_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // bits: a0 match, a1 match, en[1:0], mode, fout, exp_flag[1:0], exp_irq_n
   localparam int NV = 8;
   localparam logic [8:0] VEC [NV] = '{
      9'b1_0_01_0_0_01_0,   // R2 R6 alarm 0 alone
      9'b0_1_10_0_0_10_0,   // R11 alarm 1 alone
      9'b1_1_11_0_0_11_0,   // R11 both together
      9'b1_0_00_0_0_01_1,   // R7 flag set, no enable
      9'b1_0_10_0_0_01_1,   // R7 other alarm enabled only
      9'b1_0_01_1_0_01_0,   // R8 pulsed
      9'b1_0_01_0_1_01_1,   // R10 fout suppresses
      9'b0_0_11_0_0_00_1    // R3 no match
   };

   task automatic clear_all();
      @(negedge clk);
      sec_tick = 0; alm_en = 0; irq_mode = 0; fout_en = 0;
      stat_rd_clr = 1;
      @(negedge clk);
      stat_rd_clr = 0;
      repeat (PL + 3) @(negedge clk);
   endtask

   task automatic tick_once();
      sec_tick = 1;
      @(negedge clk);
      sec_tick = 0;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lows;
      repeat (3) @(negedge clk);
      check("R1 reset flags", 32'(alm_flag), 32'h0);
      check("R1 reset irq_n", 32'(irq_n), 32'h1);
      rst_n = 1;
      cur_time = T0;

      for (int v = 0; v < NV; v++) begin
         clear_all();
         alm0_val = VEC[v][8] ? T0 : T0 ^ 24'h1;
         alm1_val = VEC[v][7] ? T0 : T0 ^ 24'h2;
         alm_en   = VEC[v][6:5];
         irq_mode = VEC[v][4];
         fout_en  = VEC[v][3];
         tick_once();
         check($sformatf("R2 vector %0d flags", v), 32'(alm_flag), 32'(VEC[v][2:1]));
         @(negedge clk);
         check($sformatf("R6/R7/R8/R10 vector %0d irq_n", v), 32'(irq_n), 32'(VEC[v][0]));
      end

      // R3: match present but no tick
      clear_all();
      alm0_val = T0; alm1_val = T0; alm_en = 2'b11;
      repeat (3) @(negedge clk);
      check("R3 no tick flags", 32'(alm_flag), 32'h0);
      check("R3 no tick irq_n", 32'(irq_n), 32'h1);

      // R6: single mode stays low until read, then releases
      clear_all();
      alm0_val = T0; alm1_val = ~T0; alm_en = 2'b01;
      tick_once();
      repeat (10) @(negedge clk);
      check("R6 held low", 32'(irq_n), 32'h0);
      stat_rd_clr = 1;
      @(negedge clk);
      stat_rd_clr = 0;
      check("R4 cleared flags", 32'(alm_flag), 32'h0);
      check("R6 still low one cycle", 32'(irq_n), 32'h0);
      @(negedge clk);
      check("R6 released after clear", 32'(irq_n), 32'h1);

      // R5: set and clear collide
      clear_all();
      alm0_val = T0; alm1_val = ~T0; alm_en = 2'b00;
      tick_once();
      alm0_val = ~T0; alm1_val = T0;
      stat_rd_clr = 1; sec_tick = 1;
      @(negedge clk);
      stat_rd_clr = 0; sec_tick = 0;
      check("R5 set wins over clear", 32'(alm_flag), 32'h2);

      // R8 + R9: pulse length and sticky flag
      clear_all();
      alm0_val = T0; alm1_val = ~T0; alm_en = 2'b01; irq_mode = 1;
      tick_once();
      lows = 0;
      for (int c = 0; c < PL + 4; c++) begin
         @(negedge clk);
         if (irq_n == 1'b0) lows++;
      end
      check("R8 pulse length", 32'(lows), 32'(PL));
      check("R9 flag sticky after pulse", 32'(alm_flag), 32'h1);
      stat_rd_clr = 1;
      @(negedge clk);
      stat_rd_clr = 0;
      check("R9 flag cleared by read", 32'(alm_flag), 32'h0);

      // R10: fout toggled while an enabled flag is set
      clear_all();
      alm0_val = T0; alm1_val = ~T0; alm_en = 2'b01;
      tick_once();
      @(negedge clk);
      check("R10 low before fout", 32'(irq_n), 32'h0);
      fout_en = 1;
      @(negedge clk);
      check("R10 high with fout", 32'(irq_n), 32'h1);
      fout_en = 0;
      @(negedge clk);
      check("R10 low again after fout off", 32'(irq_n), 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule